// File: doc/BRIEF.md
# Multi-Channel PRBS Link Health Monitor

This block watches a link made of several parallel channels and reports one health verdict for the whole link. Each channel's pattern checker supplies a match flag that is already synchronous to the monitor clock. The monitor treats a cycle as clean only when every channel reports a match. A three-state machine (down, syncing, up) turns that clean/mismatch stream into a live link-up output.

The link-up output has hysteresis. The link is declared up only after a long unbroken run of clean cycles. Once up, a saturating error score absorbs scattered mismatches, so the link drops only when mismatches clearly outnumber clean cycles.

A sticky link-lost flag records every loss of the link. It is set at power-up and in every cycle in which the link is down. It is cleared only by an asynchronous clear input, which is first passed through a two-flop synchronizer. Both outputs belong to the single free-running clock domain.

Top module: `link_health_mon`

## Requirements
- R1: A cycle counts as clean only when all NUM_CH bits of `chan_match` are 1. A 0 on any one channel makes the cycle a mismatch.
- R2: While `rst_n` is low at a clock edge, the block is reset. After that edge, `link_up` is 0 and `link_lost` is 1.
- R3: From the down state, `link_up` becomes 1 after the edge that samples the LOCK_RUN-th (default 128) consecutive clean cycle. A mismatch before that point returns the block to the down state, and the run starts again from zero.
- R4: While the link is up, an error score starts at 0. The score rises by 1 on each mismatch cycle and falls by 1 on each clean cycle, and it never goes below 0. `link_up` stays 1 while the score is below ERR_LIMIT (default 4).
- R5: While the link is up, the mismatch that brings the score to ERR_LIMIT makes `link_up` 0 after that same edge. With defaults, four consecutive mismatches from a score of 0 drop the link.
- R6: `link_lost` becomes 1 at any clock edge at which `link_up` is 0. Once set, it stays 1 until it is cleared.
- R7: `lost_clr_async` is synchronized by two flops. If it rises and is held high while the link stays up, `link_lost` reads 0 after the third rising clock edge and not before.
- R8: If the synchronized clear is high while `link_up` is 0, the set condition wins and `link_lost` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_match | input | NUM_CH | Per-channel pattern match flags, synchronous to clk |
| lost_clr_async | input | 1 | Asynchronous, externally debounced clear for the sticky flag |
| link_up | output | 1 | Live link health, active high |
| link_lost | output | 1 | Sticky link-loss flag, active high |

## Verification
The bench checks that the lock run is exactly LOCK_RUN cycles long and that a single bad channel partway through the run restarts it. A design that is off by one or ORs the channels would lock early or never restart. The bench drives three mismatches, then a fourth, to probe the drop threshold exactly, and it interleaves errors with clean cycles to probe the score's down-count. A design with the wrong limit, or one that uses a consecutive-error count, would drop at the wrong moment. Finally, the bench times the clear path edge by edge and asserts clear while the link is down. A design that skips a synchronizer stage or gives clear priority over set would release the sticky flag early or wrongly.

// File: rtl/link_mon_pkg.sv
// Package: shared state encoding for the link health monitor.
// Assumes nothing beyond a SystemVerilog-2017 tool.
package link_mon_pkg;
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_SYNC = 2'd1,
        ST_UP   = 2'd2
    } link_state_t;
endpackage

// File: rtl/lm_match_and.sv
// Combines per-channel match flags into one clean indication.
// Assumes all inputs are synchronous to the monitor clock.
module lm_match_and #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] match_vec,
    output logic              all_clean
);
    // Purpose: a cycle is clean only when every channel matches.
    always_comb begin
        all_clean = &match_vec;
    end
endmodule

// File: rtl/lm_sync2.sv
// Two-flop synchronizer for a single asynchronous level.
// Assumes the input is debounced and held for several clock periods.
module lm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage1;

    // Purpose: resample the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/lm_link_fsm.sv
// Hysteresis state machine: locks after LOCK_RUN clean cycles.
// Drops when a saturating up/down error score reaches ERR_LIMIT.
// Assumes LOCK_RUN >= 2 and ERR_LIMIT >= 1.
module lm_link_fsm
    import link_mon_pkg::*;
#(
    parameter int LOCK_RUN  = 128,
    parameter int ERR_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_clean,
    output logic link_up
);
    localparam int RUN_W = (LOCK_RUN > 2) ? $clog2(LOCK_RUN) : 1;
    localparam int ERR_W = $clog2(ERR_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
    localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_LIMIT - 1);

    link_state_t      state;
    logic [RUN_W-1:0] run_cnt;
    logic [ERR_W-1:0] err_cnt;

    // Purpose: advance state, clean-run counter and error score.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_DOWN;
            run_cnt <= '0;
            err_cnt <= '0;
        end else begin
            case (state)
                ST_DOWN: begin
                    if (all_clean) begin
                        state   <= ST_SYNC;
                        run_cnt <= RUN_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (!all_clean) begin
                        state   <= ST_DOWN;
                        run_cnt <= '0;
                    end else if (run_cnt == RUN_LAST) begin
                        state   <= ST_UP;
                        err_cnt <= '0;
                    end else begin
                        run_cnt <= run_cnt + RUN_W'(1);
                    end
                end
                ST_UP: begin
                    if (!all_clean) begin
                        if (err_cnt == ERR_LAST) begin
                            state   <= ST_DOWN;
                            err_cnt <= '0;
                            run_cnt <= '0;
                        end else begin
                            err_cnt <= err_cnt + ERR_W'(1);
                        end
                    end else if (err_cnt != '0) begin
                        err_cnt <= err_cnt - ERR_W'(1);
                    end
                end
                default: state <= ST_DOWN;
            endcase
        end
    end

    // Purpose: live status is the registered up state.
    always_comb begin
        link_up = (state == ST_UP);
    end

    // R3
    lock_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !$past(link_up)) |-> $past(all_clean));

    // R4
    clean_keeps_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && all_clean) |=> link_up);

    // R5
    err_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt < ERR_W'(ERR_LIMIT));

    // R5
    drop_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !all_clean && err_cnt == ERR_LAST) |=> !link_up);
endmodule

// File: rtl/lm_sticky.sv
// Sticky link-loss flag: set whenever the link is down, cleared by sync clear.
// Set has priority over clear. Assumes clr_sync is already synchronized.
module lm_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic clr_sync,
    output logic link_lost
);
    // Purpose: hold loss record, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_lost <= 1'b1;
        end else if (!link_up) begin
            link_lost <= 1'b1;
        end else if (clr_sync) begin
            link_lost <= 1'b0;
        end
    end

    // R6
    down_sets_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> link_lost);

    // R7
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_lost) |-> $past(clr_sync));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && clr_sync) |=> link_lost);
endmodule

// File: rtl/link_health_mon.sv
// Top: multi-channel link health monitor with hysteresis and sticky loss flag.
// Assumes one free-running clock; chan_match synchronous, clear asynchronous.
module link_health_mon #(
    parameter int NUM_CH    = 4,
    parameter int LOCK_RUN  = 128,
    parameter int ERR_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_match,
    input  logic              lost_clr_async,
    output logic              link_up,
    output logic              link_lost
);
    logic all_clean;
    logic clr_sync;

    lm_match_and #(.NUM_CH(NUM_CH)) u_and (
        .match_vec (chan_match),
        .all_clean (all_clean)
    );

    lm_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lost_clr_async),
        .sync_out (clr_sync)
    );

    lm_link_fsm #(.LOCK_RUN(LOCK_RUN), .ERR_LIMIT(ERR_LIMIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_clean (all_clean),
        .link_up   (link_up)
    );

    lm_sticky u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .clr_sync  (clr_sync),
        .link_lost (link_lost)
    );
endmodule

// File: tb/link_health_mon_tb.sv
module link_health_mon_tb;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] chan_match = '0;
    logic           lost_clr_async = 1'b0;
    logic           link_up, link_lost;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench reference state
    int m_st = 0, m_run = 0, m_err = 0;
    bit m_up = 0, m_lost = 1, m_c1 = 0, m_c2 = 0;

    link_health_mon #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .chan_match(chan_match),
        .lost_clr_async(lost_clr_async), .link_up(link_up), .link_lost(link_lost)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic bit next_lost(bit up, bit c2, bit lost);
        return !up ? 1'b1 : (c2 ? 1'b0 : lost);
    endfunction

    // one clock: update reference on the edge, compare on the falling edge
    task automatic step();
        bit all, nl;
        @(posedge clk);
        all = &chan_match;
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_err = 0; m_lost = 1; m_c1 = 0; m_c2 = 0;
        end else begin
            nl = next_lost(m_up, m_c2, m_lost);
            m_c2 = m_c1; m_c1 = lost_clr_async;
            case (m_st)
                0: if (all) begin m_st = 1; m_run = 1; end
                1: if (!all) begin m_st = 0; m_run = 0; end
                   else if (m_run == 127) begin m_st = 2; m_err = 0; end
                   else m_run++;
                default: if (!all) begin
                       if (m_err == 3) begin m_st = 0; m_err = 0; m_run = 0; end
                       else m_err++;
                   end else if (m_err > 0) m_err--;
            endcase
            m_lost = nl;
        end
        m_up = (m_st == 2);
        @(negedge clk);
        chk("R1 R4 R5 R6 R7 model link_up", link_up, m_up);
        chk("R6 R7 R8 model link_lost", link_lost, m_lost);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        steps(3);
        chk("R2 reset link_up", link_up, 1'b0);
        chk("R2 reset link_lost", link_lost, 1'b1);
        rst_n = 1'b1;

        // R1 and R3: one bad channel restarts the lock run
        chan_match = '1;
        steps(100);
        chan_match = 4'b1011;
        step();
        chan_match = '1;
        steps(127);
        chk("R3 not up after 127 clean", link_up, 1'b0);
        step();
        chk("R3 up after 128 clean", link_up, 1'b1);
        chk("R6 sticky still set", link_lost, 1'b1);

        // R7: clear timing through the synchronizer
        lost_clr_async = 1'b1;
        steps(2);
        chk("R7 not cleared after 2 edges", link_lost, 1'b1);
        step();
        chk("R7 cleared after 3 edges", link_lost, 1'b0);
        lost_clr_async = 1'b0;
        steps(3);

        // R4: scattered errors tolerated
        chan_match = 4'b0111; step();
        chan_match = '1; step();
        chk("R4 single error tolerated", link_up, 1'b1);
        chan_match = 4'b1110; steps(3);
        chk("R4 three errors tolerated", link_up, 1'b1);
        chan_match = '1; steps(5);
        chan_match = 4'b0000; step();
        chan_match = '1; step();
        chan_match = 4'b0000; steps(3);
        chk("R4 score decrements on clean", link_up, 1'b1);
        chan_match = '1; steps(4);

        // R5 and R6: four consecutive errors drop, then sticky sets
        chan_match = 4'b1101; steps(3);
        chk("R5 up after three misses", link_up, 1'b1);
        step();
        chk("R5 down after fourth miss", link_up, 1'b0);
        chk("R6 lost not yet set", link_lost, 1'b0);
        step();
        chk("R6 lost set after down", link_lost, 1'b1);

        // R8: clear while down does not release
        lost_clr_async = 1'b1;
        steps(6);
        chk("R8 set wins over clear", link_lost, 1'b1);
        lost_clr_async = 1'b0;
        steps(2);

        // random phase with clean bursts so the link locks
        for (int b = 0; b < 20; b++) begin
            chan_match = '1;
            steps(130 + ($urandom % 10));
            for (int i = 0; i < 150; i++) begin
                for (int c = 0; c < NCH; c++)
                    chan_match[c] = (($urandom % 40) != 0);
                lost_clr_async = (($urandom % 30) == 0) ? ~lost_clr_async : lost_clr_async;
                step();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule